// File: doc/BRIEF.md
# SPI Command-Queue Master Engine

This block is a SPI master that carries out a whole transaction by itself from a descriptor placed in local memory. Software programs a clock configuration, a per-channel descriptor address and a per-channel receive buffer address through a byte-wide register port, then sets a run bit together with a channel select bit. The engine fetches an 8-byte header, shifts out up to 16 inline command bytes that follow the header, and then either streams a data phase out of memory or captures a data phase from the serial line into memory. At the end it raises a status bit and, if enabled, an interrupt.

Memory is reached through a simple synchronous port: a request with a read address returns its byte on `mem_rdata` in the next cycle, and a request with `mem_we` high writes `mem_wdata`. Two chip selects are provided, one per channel. The serial side is single-line, 8-bit, MSB first, with data sampled on the first SCK edge of each bit (clock phase 0) and either clock polarity.

Header bytes: 0 = command length, 1 = flags, 2..3 = data length (low byte first), 4..5 = transmit data address bits 15:0 (low byte first), 6 = bits 1:0 give transmit address bits 17:16, 7 = unused. Command bytes are at header offset 8 onward. Flags bit 1 selects receive (1) or transmit (0); bit 3 keeps the chip select low after the end; bits 0, 2 and 4..7 have no effect.

The controller has eight states. IDLE waits for a start. IDLE goes to FETCH when the run bit and a select bit are set. FETCH reads the header and then goes to CMD_RD if the command length is non-zero, otherwise directly to the data phase. CMD_RD reads one command byte and goes to CMD_SH, which shifts it; CMD_SH returns to CMD_RD while command bytes remain, and otherwise enters the data phase. The data phase goes to END if the data length is zero, to DAT_RD for transmit, or to DAT_SH for receive. DAT_RD reads one transmit byte and goes to DAT_SH. DAT_SH goes back to DAT_RD for the next transmit byte, to RX_WR after a received byte, or to END. RX_WR stores the byte and goes to DAT_SH or END. END sets the status, clears the channel's select bit and returns to IDLE.

Register map (byte offsets): 0x00 config (bit 1 interrupt enable, bits 4:2 clock code, bit 6 clock polarity); 0x01 run control (bit 0 run, bit 1 clock bypass, bit 4 select channel 0, bit 5 select channel 1); 0x02 status (bit 0 end of transaction, write 1 to clear). For channel c, the descriptor address is at 0x08+8c..0x0A+8c and the receive address is at 0x0B+8c..0x0D+8c, low byte first.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset the engine is idle: `cs_n` is all ones, SCK sits at the polarity level, `mem_req` stays low, the status bit and `irq` are 0.
- R2: A transaction reads the 8 header bytes from the channel's descriptor address and then shifts out min(header byte 0, 16) command bytes read from descriptor address + 8 onward.
- R3: Bytes go out MSB first. MOSI changes only on the trailing SCK edge and MISO is sampled on the leading edge. SCK idles at config bit 6.
- R4: One SCK period lasts 2*(code+1) clock cycles, where code is config bits 4:2. When run bit 1 is set, the period is 2 cycles whatever the code.
- R5: With flags bit 1 = 0, the data-length bytes are read from the 18-bit address {header6[1:0], header5, header4} upward and shifted out after the command bytes.
- R6: With flags bit 1 = 1, the data-length bytes are received while MOSI is held low, and are written to the channel's receive address upward.
- R7: A transaction starts when run bit 0 and a select bit (bit 4 for channel 0, bit 5 for channel 1) are set. Channel 0 wins if both are set. The engine clears the served select bit at the end.
- R8: At the end of a transaction status bit 0 is set. Writing 1 to it clears it, and writing 0 leaves it unchanged. `irq` is high when the status bit and config bit 1 are both set.
- R9: Only the served channel's chip select goes low during a transaction. With flags bit 3 set it stays low after the end, and otherwise it returns high.
- R10: Writes to the descriptor and receive address registers are ignored while a transaction runs.
- R11: A descriptor with zero command and data lengths completes with no SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | End-of-transaction interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCH | Active-low chip selects, one per channel |

## Verification
The bench sweeps every clock code under both polarities and measures the SCK period. An off-by-one divider, or a polarity that leaks into the idle level, shows up as a wrong period or a missing first edge. It runs a command length above 16, which a design without clamping would turn into runaway shifting past the header area. It also runs a transmit address with bits 17:16 set, which a design that drops the extra address bits would fetch from the wrong page. Receive runs compare memory against the byte pattern driven by the bench's slave model, so a byte shifted one bit off or stored one address off cannot pass. The bench also covers a held chip select followed by a transaction on the other channel, an address write during a run, simultaneous selects, and the write-one-to-clear rule.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CMD_RD, S_CMD_SH, S_DAT_RD, S_DAT_SH, S_RX_WR, S_END
    } spiq_state_e;

    localparam int REG_CFG    = 0;
    localparam int REG_RUN    = 1;
    localparam int REG_STAT   = 2;
    localparam int CH_REG0    = 8;
    localparam int CH_STRIDE  = 8;
    localparam int ADDR_BYTES = 3;
    localparam int HDR_BYTES  = 8;
    localparam int CMD_MAX    = 16;
    localparam int RUN_SEL0   = 4;
    localparam int TX_AW      = 18;
endpackage

// File: rtl/spiq_tick.sv
module spiq_tick #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] half,
    output logic          tick
);
    logic [HW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == half - HW'(1));
    assign tick = en && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en)    cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + HW'(1);
    end
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] tx_byte,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic          lvl,
    output logic          mosi,
    output logic [BW-1:0] rx_byte
);
    localparam int CW = $clog2(BW);
    logic [BW-1:0] sh_q;
    logic [CW-1:0] bit_q;

    assign mosi = sh_q[BW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0; bit_q <= '0; busy <= 1'b0;
            done <= 1'b0; lvl <= 1'b0; rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh_q  <= tx_byte;
                bit_q <= '0;
                lvl   <= 1'b0;
                busy  <= 1'b1;
            end else if (busy && tick) begin
                if (!lvl) begin
                    lvl     <= 1'b1;
                    rx_byte <= {rx_byte[BW-2:0], miso};
                end else begin
                    lvl <= 1'b0;
                    if (bit_q == CW'(BW-1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sh_q  <= {sh_q[BW-2:0], 1'b0};
                        bit_q <= bit_q + CW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
    import spiq_pkg::*;
#(
    parameter int AW  = 24,
    parameter int NCH = 2,
    parameter int RAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NCH-1:0] cs_n
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int RW  = 8 * ADDR_BYTES;

    logic [7:0]    cfg_q, run_q;
    logic          stat_q;
    logic [RW-1:0] dsc_base [NCH];
    logic [RW-1:0] rxb_base [NCH];

    spiq_state_e    state_q, state_d;
    logic [CHW-1:0] ch_q, pick;
    logic [7:0]     hdr_q [HDR_BYTES];
    logic [3:0]     fcnt_q;
    logic [2:0]     cap_q;
    logic           rdv_q, launch_q;
    logic [15:0]    idx_q;
    logic [16:0]    idx_nx;
    logic [NCH-1:0] cs_n_q, sel;
    logic           busy, finishing, go;

    logic [4:0]    cmd_n;
    logic [15:0]   dat_n;
    logic          rd_dir, keep;
    logic [RW-1:0] tx_base;
    spiq_state_e   data_entry;

    logic       sh_start, sh_done, sh_busy, sh_lvl, tick;
    logic [7:0] sh_tx, sh_rx;
    logic [3:0] half;

    assign busy      = (state_q != S_IDLE);
    assign finishing = (state_q == S_END);
    assign sel       = run_q[RUN_SEL0 +: NCH];
    assign go        = run_q[0] && (|sel);
    assign cmd_n     = (hdr_q[0] > 8'(CMD_MAX)) ? 5'(CMD_MAX) : hdr_q[0][4:0];
    assign dat_n     = {hdr_q[3], hdr_q[2]};
    assign rd_dir    = hdr_q[1][1];
    assign keep      = hdr_q[1][3];
    assign tx_base   = RW'({hdr_q[6][TX_AW-17:0], hdr_q[5], hdr_q[4]});
    assign idx_nx    = {1'b0, idx_q} + 17'd1;
    assign data_entry = (dat_n == 16'd0) ? S_END : (rd_dir ? S_DAT_SH : S_DAT_RD);
    assign half      = run_q[1] ? 4'd1 : ({1'b0, cfg_q[4:2]} + 4'd1);
    assign irq       = stat_q & cfg_q[1];
    assign sck       = cfg_q[6] ^ sh_lvl;
    assign cs_n      = cs_n_q;

    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) if (sel[c]) pick = CHW'(c);
    end

    // control, run and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0; run_q <= '0; stat_q <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RAW'(REG_CFG))  cfg_q <= reg_wdata;
            if (reg_we && reg_addr == RAW'(REG_RUN))  run_q <= reg_wdata;
            if (reg_we && reg_addr == RAW'(REG_STAT) && reg_wdata[0]) stat_q <= 1'b0;
            if (finishing) begin
                stat_q <= 1'b1;
                run_q[RUN_SEL0 + int'(ch_q)] <= 1'b0;
            end
        end
    end

    // per-channel address registers, frozen while busy
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dsc_base[c] <= '0;
                rxb_base[c] <= '0;
            end else if (reg_we && !busy) begin
                for (int k = 0; k < ADDR_BYTES; k++) begin
                    if (reg_addr == RAW'(CH_REG0 + CH_STRIDE * c + k))
                        dsc_base[c][8*k +: 8] <= reg_wdata;
                    if (reg_addr == RAW'(CH_REG0 + CH_STRIDE * c + ADDR_BYTES + k))
                        rxb_base[c][8*k +: 8] <= reg_wdata;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == RAW'(REG_CFG))  reg_rdata = cfg_q;
        if (reg_addr == RAW'(REG_RUN))  reg_rdata = run_q;
        if (reg_addr == RAW'(REG_STAT)) reg_rdata = {7'd0, stat_q};
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (reg_addr == RAW'(CH_REG0 + CH_STRIDE * c + k))
                    reg_rdata = dsc_base[c][8*k +: 8];
                if (reg_addr == RAW'(CH_REG0 + CH_STRIDE * c + ADDR_BYTES + k))
                    reg_rdata = rxb_base[c][8*k +: 8];
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go) state_d = S_FETCH;
            S_FETCH:  if (rdv_q && cap_q == 3'd7)
                          state_d = (cmd_n != 5'd0) ? S_CMD_RD : data_entry;
            S_CMD_RD: state_d = S_CMD_SH;
            S_CMD_SH: if (sh_done)
                          state_d = (idx_nx < 17'(cmd_n)) ? S_CMD_RD : data_entry;
            S_DAT_RD: state_d = S_DAT_SH;
            S_DAT_SH: if (sh_done) begin
                          if (rd_dir)                  state_d = S_RX_WR;
                          else if (idx_nx < 17'(dat_n)) state_d = S_DAT_RD;
                          else                          state_d = S_END;
                      end
            S_RX_WR:  state_d = (idx_nx < 17'(dat_n)) ? S_DAT_SH : S_END;
            S_END:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // sequencing datapath and chip selects
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0; fcnt_q <= '0; cap_q <= '0; rdv_q <= 1'b0;
            launch_q <= 1'b0; idx_q <= '0; cs_n_q <= '1;
            for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= '0;
        end else begin
            launch_q <= (state_d == S_CMD_SH || state_d == S_DAT_SH) && (state_d != state_q);
            rdv_q    <= (state_q == S_FETCH) && !fcnt_q[3];
            cap_q    <= fcnt_q[2:0];
            if (rdv_q) hdr_q[cap_q] <= mem_rdata;
            unique case (state_q)
                S_IDLE: if (go) begin
                    ch_q   <= pick;
                    fcnt_q <= '0;
                    cs_n_q <= ~(NCH'(1) << pick);
                end
                S_FETCH: begin
                    if (!fcnt_q[3]) fcnt_q <= fcnt_q + 4'd1;
                    idx_q <= '0;
                end
                S_CMD_SH: if (sh_done) idx_q <= (idx_nx < 17'(cmd_n)) ? idx_nx[15:0] : 16'd0;
                S_DAT_SH: if (sh_done && !rd_dir) idx_q <= idx_nx[15:0];
                S_RX_WR:  idx_q <= idx_nx[15:0];
                S_END:    if (!keep) cs_n_q <= '1;
                default: ;
            endcase
        end
    end

    // memory port and shifter feed
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = sh_rx;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = !fcnt_q[3];
                mem_addr = AW'(dsc_base[ch_q] + RW'(fcnt_q));
            end
            S_CMD_RD: begin
                mem_req  = 1'b1;
                mem_addr = AW'(dsc_base[ch_q] + RW'(HDR_BYTES) + RW'(idx_q));
            end
            S_DAT_RD: begin
                mem_req  = 1'b1;
                mem_addr = AW'(tx_base + RW'(idx_q));
            end
            S_RX_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = AW'(rxb_base[ch_q] + RW'(idx_q));
            end
            default: ;
        endcase
    end

    assign sh_start = launch_q;
    assign sh_tx    = (state_q == S_DAT_SH && rd_dir) ? 8'h00 : mem_rdata;

    spiq_tick #(.HW(4)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(sh_busy), .half(half), .tick(tick)
    );

    spiq_shifter #(.BW(8)) shift_i (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .tick(tick),
        .miso(miso), .busy(sh_busy), .done(sh_done), .lvl(sh_lvl), .mosi(mosi),
        .rx_byte(sh_rx)
    );
endmodule

// File: rtl/spi_cmdq_master_chk.sv
module spi_cmdq_master_chk #(
    parameter int NCH = 2,
    parameter int RAW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           finishing,
    input logic [NCH-1:0] cs_n,
    input logic           sck,
    input logic           cpol,
    input logic           mem_req,
    input logic           reg_we,
    input logic [RAW-1:0] reg_addr,
    input logic [7:0]     reg_wdata,
    input logic           stat,
    input logic [23:0]    dsc0
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    assert_stat_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |-> $past(finishing));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RAW'(2) && reg_wdata[0] && !finishing) |=> !stat);

    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cs_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != cpol) |-> (cs_n != '1));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dsc0));
endmodule

bind spi_cmdq_master spi_cmdq_master_chk #(.NCH(NCH), .RAW(RAW)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .finishing(finishing), .cs_n(cs_n),
    .sck(sck), .cpol(cfg_q[6]), .mem_req(mem_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat(stat_q), .dsc0(dsc_base[0])
);

// File: tb/spi_cmdq_master_tb_top.sv
module spi_cmdq_master_tb_top;
    localparam int AW = 24, NCH = 2, RAW = 6;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [RAW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, mem_req, mem_we, sck, mosi, miso;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [NCH-1:0] cs_n;

    always #2 clk = ~clk;

    spi_cmdq_master #(.AW(AW), .NCH(NCH), .RAW(RAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit done_flag = 0;
    logic [7:0] mem [0:4095];
    logic tb_cpol = 0;
    int s_le = 0;
    logic [7:0] s_bytes [0:63];
    time t_le0, t_le1;
    bit cs0_seen, cs1_seen, hi_seen, req_seen;

    function automatic logic [7:0] spat(int k);
        return 8'(k * 29 + 8'h5A);
    endfunction

    // memory model
    always @(posedge clk) if (mem_req) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:0]];
    end

    // slave model: sample MOSI and advance MISO on the leading edge
    assign miso = spat(s_le / 8)[7 - (s_le % 8)];
    always @(sck) if (cs_n != 2'b11 && sck != tb_cpol) begin
        if (s_le == 0) t_le0 = $time;
        if (s_le == 1) t_le1 = $time;
        if (s_le < 512) s_bytes[s_le / 8] = {s_bytes[s_le / 8][6:0], mosi};
        s_le = s_le + 1;
    end

    always @(negedge clk) begin
        if (!cs_n[0]) cs0_seen = 1;
        if (!cs_n[1]) cs1_seen = 1;
        if (mem_req && !mem_we && mem_addr[17:16] == 2'b10) hi_seen = 1;
        if (mem_req) req_seen = 1;
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(int a, logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = RAW'(a); reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_rd(int a, output logic [7:0] d);
        @(negedge clk); reg_addr = RAW'(a); #1; d = reg_rdata;
    endtask

    task automatic set_chan(int c, int dsc, int rxa);
        for (int k = 0; k < 3; k++) begin
            reg_wr(8 + 8 * c + k, 8'(dsc >> (8 * k)));
            reg_wr(11 + 8 * c + k, 8'(rxa >> (8 * k)));
        end
    endtask

    task automatic put_desc(int base, int cl, int fl, int dl, int da, int mk);
        mem[base] = 8'(cl); mem[base + 1] = 8'(fl);
        mem[base + 2] = 8'(dl); mem[base + 3] = 8'(dl >> 8);
        mem[base + 4] = 8'(da); mem[base + 5] = 8'(da >> 8);
        mem[base + 6] = 8'(mk); mem[base + 7] = 8'h00;
        for (int i = 0; i < 16; i++) mem[base + 8 + i] = 8'(base + i * 13 + 1);
    endtask

    task automatic slave_clear();
        s_le = 0; cs0_seen = 0; cs1_seen = 0; hi_seen = 0;
        for (int i = 0; i < 64; i++) s_bytes[i] = 8'h00;
    endtask

    task automatic wait_done();
        logic [7:0] st;
        st = 0;
        for (int i = 0; i < 20000 && !st[0]; i++) reg_rd(2, st);
    endtask

    task automatic clear_stat();
        reg_wr(2, 8'h01);
    endtask

    // transmit run on channel 0, descriptor at 0x100, data at 0x400
    task automatic tx_run(int cl, int dl, int mk, bit byp);
        logic [7:0] st;
        int bad, ncmd;
        put_desc(12'h100, cl, 8'h00, dl, 12'h400, mk);
        slave_clear();
        reg_wr(1, byp ? 8'h13 : 8'h11);
        wait_done();
        ncmd = (cl > 16) ? 16 : cl;
        bad = 0;
        for (int k = 0; k < ncmd + dl; k++)
            if (s_bytes[k] != ((k < ncmd) ? mem[12'h108 + k] : mem[12'h400 + k - ncmd])) bad++;
        check(bad == 0, "R2 R5 R3 mosi bytes", bad, 0);
        check(s_le == 8 * (ncmd + dl), "R2 edge count", s_le, 8 * (ncmd + dl));
        reg_rd(2, st);
        check(st[0] == 1'b1, "R8 status set", st, 1);
        check(cs_n == 2'b11, "R9 cs released", cs_n, 3);
    endtask

    initial begin
        logic [7:0] rd;
        for (int a = 0; a < 4096; a++) mem[a] = 8'(a * 7 + 3);
        req_seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);
        // R1 reset state
        check(cs_n == 2'b11, "R1 cs idle", cs_n, 3);
        check(sck == 1'b0, "R1 sck idle", sck, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(req_seen == 0, "R1 no memory access", req_seen, 0);
        reg_rd(2, rd);
        check(rd == 8'h00, "R1 status", rd, 0);

        set_chan(0, 12'h100, 12'h800);
        set_chan(1, 12'h200, 12'h900);

        // sweep clock codes and polarities (R3 R4)
        for (int p = 0; p < 2; p++) begin
            for (int code = 0; code < 8; code++) begin
                tb_cpol = 1'(p);
                reg_wr(0, 8'((p << 6) | (code << 2) | 2));
                tx_run(2, 3, 0, 0);
                check((t_le1 - t_le0) / 4 == 2 * (code + 1), "R4 sck period",
                      int'((t_le1 - t_le0) / 4), 2 * (code + 1));
                check(irq == 1'b1, "R8 irq raised", irq, 1);
                check(sck == tb_cpol, "R3 sck idle level", sck, tb_cpol);
                clear_stat();
                check(irq == 1'b0, "R8 irq cleared", irq, 0);
            end
        end
        tb_cpol = 0;

        // bypass gives a two-cycle period (R4)
        reg_wr(0, 8'h16);
        tx_run(1, 1, 0, 1);
        check((t_le1 - t_le0) / 4 == 2, "R4 bypass period", int'((t_le1 - t_le0) / 4), 2);
        clear_stat();
        reg_wr(0, 8'h02);

        // command length clamp (R2) and high transmit address bits (R5)
        tx_run(20, 0, 0, 0);
        clear_stat();
        tx_run(1, 4, 2, 0);
        check(hi_seen == 1, "R5 address bits 17:16", hi_seen, 1);
        clear_stat();

        // receive on channel 1 (R6 R7 R9)
        put_desc(12'h200, 3, 8'h02, 6, 0, 0);
        slave_clear();
        reg_wr(1, 8'h21);
        wait_done();
        begin
            int bad = 0;
            for (int j = 0; j < 6; j++) if (mem[12'h900 + j] != spat(3 + j)) bad++;
            check(bad == 0, "R6 received bytes stored", bad, 0);
            bad = 0;
            for (int j = 3; j < 9; j++) if (s_bytes[j] != 8'h00) bad++;
            check(bad == 0, "R6 mosi low in receive", bad, 0);
        end
        check(cs0_seen == 0 && cs1_seen == 1, "R9 only channel 1 selected",
              {cs0_seen, cs1_seen}, 1);
        reg_rd(1, rd);
        check(rd == 8'h01, "R7 select auto-cleared", rd, 8'h01);
        clear_stat();

        // keep chip select active, then release by the other channel (R9)
        put_desc(12'h100, 1, 8'h08, 1, 12'h400, 0);
        reg_wr(1, 8'h11);
        wait_done();
        check(cs_n == 2'b10, "R9 cs held low", cs_n, 2);
        clear_stat();
        put_desc(12'h200, 0, 8'h00, 0, 0, 0);
        reg_wr(1, 8'h21);
        wait_done();
        check(cs_n == 2'b11, "R9 cs released after next", cs_n, 3);
        clear_stat();

        // zero-length descriptor (R11)
        put_desc(12'h100, 0, 8'h00, 0, 0, 0);
        slave_clear();
        reg_wr(1, 8'h11);
        wait_done();
        check(s_le == 0, "R11 no sck edges", s_le, 0);
        reg_rd(2, rd);
        check(rd[0] == 1'b1, "R11 completes", rd, 1);
        clear_stat();

        // address write ignored while running (R10)
        put_desc(12'h100, 16, 8'h00, 2, 12'h400, 0);
        reg_wr(0, 8'h0E);
        reg_wr(1, 8'h11);
        repeat (40) @(negedge clk);
        reg_wr(8, 8'hAA);
        wait_done();
        reg_rd(8, rd);
        check(rd == 8'h00, "R10 write ignored when busy", rd, 0);
        clear_stat();
        reg_wr(8, 8'h00);

        // interrupt disabled, write-zero and write-one to status (R8)
        reg_wr(0, 8'h00);
        put_desc(12'h100, 1, 8'h00, 0, 0, 0);
        reg_wr(1, 8'h11);
        wait_done();
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        reg_wr(2, 8'h00);
        reg_rd(2, rd);
        check(rd[0] == 1'b1, "R8 write zero keeps status", rd, 1);
        reg_wr(2, 8'h01);
        reg_rd(2, rd);
        check(rd[0] == 1'b0, "R8 write one clears status", rd, 0);

        // both selects: channel 0 first (R7)
        put_desc(12'h100, 0, 8'h00, 0, 0, 0);
        put_desc(12'h200, 0, 8'h00, 0, 0, 0);
        slave_clear();
        reg_wr(1, 8'h31);
        wait_done();
        check(cs0_seen == 1 && cs1_seen == 0, "R7 channel 0 priority",
              {cs0_seen, cs1_seen}, 2);
        clear_stat();
        wait_done();
        reg_rd(1, rd);
        check(rd == 8'h01, "R7 both selects served", rd, 8'h01);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule